// File: doc/BRIEF.md
# Symmetric Deglitch Filter for Three-Phase Bridge Commands

This block cleans up the six logic-level commands that steer a three-phase half-bridge driver: one high-side and one low-side command per phase. Each command is brought into the system clock domain through a two-stage synchronizer. It then passes through its own filter, which accepts a new level only after that level has stayed unchanged for a programmable number of clock cycles (`FILT_CYCLES`).

Both the rising and the falling transition wait for the same confirmation time, so an accepted pulse comes out with the same width it had at the input. The whole pulse is shifted later by a fixed latency. A plain counter deglitcher behaves differently: it confirms only one edge and shortens every pulse by the filter time. Glitches shorter than the filter time disappear in both directions, whether they are a short rise on a low command or a short drop on a high command. The filtered commands go to the downstream bridge logic. Commands are active low, so the idle level is high.

Top module: `bridge_input_filter`

## Requirements
- R1: Each of the six commands (hs_cmd_in[0..2] mapped to hs_cmd_flt[0..2], ls_cmd_in[0..2] mapped to ls_cmd_flt[0..2]) is filtered on its own. Activity on one command leaves every other filtered output unchanged.
- R2: A level change that holds is reported with a fixed latency. If an input changes just before rising edge n and then stays put, the matching output takes the new level right after rising edge n+FILT_CYCLES+1. That latency is two synchronizer cycles plus FILT_CYCLES confirmation cycles.
- R3: On a command that is low, a high pulse that is seen on fewer than FILT_CYCLES consecutive rising edges leaves the output low.
- R4: On a command that is high, a low pulse that is seen on fewer than FILT_CYCLES consecutive rising edges leaves the output high.
- R5: A pulse of either polarity that is seen on W ≥ FILT_CYCLES consecutive rising edges produces an output pulse exactly W cycles wide, with both of its edges delayed by the same latency as in R2.
- R6: If the input returns to the current output level at any point in the confirmation window, the window starts over. Two short excursions separated by a one-cycle return therefore do not add up, and the output stays unchanged.
- R7: Synchronous active-high reset drives all six filtered outputs to the inactive level 1 on the next rising edge, whatever the inputs are. The outputs stay at 1 after reset until a new input level has been confirmed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| hs_cmd_in | input | NUM_PHASES | Raw high-side commands, one per phase, asynchronous to clk |
| ls_cmd_in | input | NUM_PHASES | Raw low-side commands, one per phase, asynchronous to clk |
| hs_cmd_flt | output | NUM_PHASES | Filtered high-side commands |
| ls_cmd_flt | output | NUM_PHASES | Filtered low-side commands |

## Verification
The bench targets the boundary at FILT_CYCLES-1 versus FILT_CYCLES edges, in both polarities. A design that is off by one would either pass a glitch or drop a legitimate minimum-width pulse. For every accepted pulse the bench measures both the output width and the latency of the leading edge. A filter that confirms only one edge would produce pulses shortened by the filter time, and one with an extra register stage would show a shifted latency. The bench also sends two short excursions separated by a one-cycle return, which catches a counter that fails to restart. It drives channels at the same time with different widths, which exposes any shared counter. Finally it checks the output level during reset and immediately after it.

// File: rtl/bridge_filt_pkg.sv
`timescale 1ns/1ps
package bridge_filt_pkg;

    // Commands are active low: the idle (switch-off) level is high.
    localparam logic CMD_IDLE_LEVEL = 1'b1;

    // One phase leg: high-side and low-side command.
    typedef struct packed {
        logic hs;
        logic ls;
    } leg_cmd_t;

    // Per-cycle decision of one filter channel.
    typedef enum logic [1:0] {
        ACT_SETTLED = 2'd0,  // sample agrees with held level
        ACT_CONFIRM = 2'd1,  // sample differs, window still running
        ACT_COMMIT  = 2'd2   // sample differed for the full window
    } filt_act_e;

    function automatic filt_act_e filt_decide(logic sample, logic held, logic last_step);
        if (sample == held)
            return ACT_SETTLED;
        else if (last_step)
            return ACT_COMMIT;
        else
            return ACT_CONFIRM;
    endfunction

    // Bits needed to count 0 .. n-1 (at least one bit).
    function automatic int unsigned cnt_width(int unsigned n);
        return (n < 2) ? 1 : $clog2(n);
    endfunction

endpackage

// File: rtl/cmd_sync.sv
`timescale 1ns/1ps
module cmd_sync #(
    parameter int unsigned WIDTH   = 6,
    parameter logic        RST_LVL = 1'b1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);
    localparam logic [WIDTH-1:0] RST_VEC = {WIDTH{RST_LVL}};

    logic [WIDTH-1:0] meta_q;
    logic [WIDTH-1:0] stable_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta_q   <= RST_VEC;
            stable_q <= RST_VEC;
        end else begin
            meta_q   <= async_i;
            stable_q <= meta_q;
        end
    end

    assign sync_o = stable_q;
endmodule

// File: rtl/deglitch_chan.sv
`timescale 1ns/1ps
module deglitch_chan
    import bridge_filt_pkg::*;
#(
    parameter int unsigned FILT_CYCLES = 8,
    parameter logic        RST_LEVEL   = CMD_IDLE_LEVEL
) (
    input  logic clk,
    input  logic rst,
    input  logic sample_i,
    output logic level_o
);
    localparam int unsigned   CW   = cnt_width(FILT_CYCLES);
    localparam logic [CW-1:0] LAST = CW'(FILT_CYCLES - 1);

    logic          held_q;
    logic [CW-1:0] cnt_q;
    filt_act_e     act;

    always_comb act = filt_decide(sample_i, held_q, cnt_q == LAST);

    // Same confirmation window on both edges keeps pulse width intact.
    always_ff @(posedge clk) begin
        if (rst) begin
            held_q <= RST_LEVEL;
            cnt_q  <= '0;
        end else begin
            unique case (act)
                ACT_CONFIRM: cnt_q <= cnt_q + CW'(1);
                ACT_COMMIT: begin
                    held_q <= sample_i;
                    cnt_q  <= '0;
                end
                default: cnt_q <= '0;
            endcase
        end
    end

    assign level_o = held_q;

    // ---------------- checker state: run length of the input level ----------
    localparam int unsigned   RW   = $clog2(FILT_CYCLES + 1);
    localparam logic [RW-1:0] RMAX = RW'(FILT_CYCLES);

    logic [RW-1:0] run_q;
    logic          last_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            run_q  <= '0;
            last_q <= RST_LEVEL;
        end else begin
            last_q <= sample_i;
            if (sample_i != last_q)
                run_q <= RW'(1);
            else if (run_q < RMAX)
                run_q <= run_q + RW'(1);
        end
    end

    // R3 / R4: an output change needs FILT_CYCLES stable samples of the new level
    a_r3_change_needs_run: assert property (@(posedge clk) disable iff (rst)
        (held_q != $past(held_q)) |-> (run_q == RMAX && last_q == held_q));

    // R2: a level stable for the full window has been committed
    a_r2_commit_after_run: assert property (@(posedge clk) disable iff (rst)
        (run_q == RMAX) |-> (held_q == last_q));

    // R6: window counter never passes the last step
    a_r6_window_bound: assert property (@(posedge clk) disable iff (rst)
        (cnt_q <= LAST));

    // R7: reset forces the inactive level
    a_r7_reset_level: assert property (@(posedge clk)
        $past(rst) |-> (held_q == RST_LEVEL));

endmodule

// File: rtl/filter_leg.sv
`timescale 1ns/1ps
module filter_leg
    import bridge_filt_pkg::*;
#(
    parameter int unsigned FILT_CYCLES = 8
) (
    input  logic     clk,
    input  logic     rst,
    input  leg_cmd_t raw_i,
    output leg_cmd_t flt_o
);
    deglitch_chan #(.FILT_CYCLES(FILT_CYCLES), .RST_LEVEL(CMD_IDLE_LEVEL)) hs_chan_i (
        .clk      (clk),
        .rst      (rst),
        .sample_i (raw_i.hs),
        .level_o  (flt_o.hs)
    );

    deglitch_chan #(.FILT_CYCLES(FILT_CYCLES), .RST_LEVEL(CMD_IDLE_LEVEL)) ls_chan_i (
        .clk      (clk),
        .rst      (rst),
        .sample_i (raw_i.ls),
        .level_o  (flt_o.ls)
    );
endmodule

// File: rtl/bridge_input_filter.sv
`timescale 1ns/1ps
module bridge_input_filter
    import bridge_filt_pkg::*;
#(
    parameter int unsigned NUM_PHASES  = 3,
    parameter int unsigned FILT_CYCLES = 8
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [NUM_PHASES-1:0] hs_cmd_in,
    input  logic [NUM_PHASES-1:0] ls_cmd_in,
    output logic [NUM_PHASES-1:0] hs_cmd_flt,
    output logic [NUM_PHASES-1:0] ls_cmd_flt
);
    localparam int unsigned NCH = 2 * NUM_PHASES;

    logic [NCH-1:0] sync_vec;

    cmd_sync #(.WIDTH(NCH), .RST_LVL(CMD_IDLE_LEVEL)) sync_i (
        .clk     (clk),
        .rst     (rst),
        .async_i ({ls_cmd_in, hs_cmd_in}),
        .sync_o  (sync_vec)
    );

    for (genvar p = 0; p < NUM_PHASES; p++) begin : g_leg
        leg_cmd_t raw_leg;
        leg_cmd_t flt_leg;

        assign raw_leg.hs = sync_vec[p];
        assign raw_leg.ls = sync_vec[NUM_PHASES + p];

        filter_leg #(.FILT_CYCLES(FILT_CYCLES)) leg_i (
            .clk   (clk),
            .rst   (rst),
            .raw_i (raw_leg),
            .flt_o (flt_leg)
        );

        assign hs_cmd_flt[p] = flt_leg.hs;
        assign ls_cmd_flt[p] = flt_leg.ls;
    end

    // R1: with all raw inputs idle for the synchronizer depth, no output leaves idle
    a_r1_idle_stays_idle: assert property (@(posedge clk) disable iff (rst)
        (&{ls_cmd_flt, hs_cmd_flt} && &sync_vec) |=> &{ls_cmd_flt, hs_cmd_flt});

endmodule

// File: tb/bridge_input_filter_tb_top.sv
`timescale 1ns/1ps
module bridge_input_filter_tb_top;
    localparam int NPH  = 3;
    localparam int FILT = 8;
    localparam int NCH  = 2 * NPH;
    localparam int NVEC = 10;

    // vector: {base level[11], channel[10:8], width[7:0]}
    localparam logic [11:0] VECS [NVEC] = '{
        {1'b1, 3'd0, 8'd7},   // R4 dip one short of window
        {1'b1, 3'd0, 8'd8},   // R5 dip exactly window
        {1'b1, 3'd1, 8'd12},  // R5
        {1'b0, 3'd2, 8'd7},   // R3 spike one short
        {1'b0, 3'd3, 8'd8},   // R5
        {1'b0, 3'd4, 8'd20},  // R5
        {1'b1, 3'd5, 8'd1},   // R4
        {1'b0, 3'd5, 8'd30},  // R5
        {1'b1, 3'd3, 8'd9},   // R5
        {1'b0, 3'd1, 8'd2}    // R3
    };

    logic           clk = 1'b0;
    logic           rst = 1'b1;
    logic [NPH-1:0] hs_in = '1;
    logic [NPH-1:0] ls_in = '1;
    logic [NPH-1:0] hs_out;
    logic [NPH-1:0] ls_out;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    bridge_input_filter #(.NUM_PHASES(NPH), .FILT_CYCLES(FILT)) dut_i (
        .clk        (clk),
        .rst        (rst),
        .hs_cmd_in  (hs_in),
        .ls_cmd_in  (ls_in),
        .hs_cmd_flt (hs_out),
        .ls_cmd_flt (ls_out)
    );

    function automatic logic [NCH-1:0] outs();
        return {ls_out, hs_out};
    endfunction

    task automatic set_ch(int ch, logic v);
        if (ch < NPH) hs_in[ch] = v;
        else          ls_in[ch - NPH] = v;
    endtask

    task automatic check(bit ok, string req, string what, int act, int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic wait_neg(int n);
        repeat (n) @(negedge clk);
    endtask

    // Drive one excursion of w edges away from base on channel ch, measure output.
    task automatic run_pulse(int ch, logic base, int w);
        logic [NCH-1:0] ref_o;
        logic [NCH-1:0] o;
        logic [NCH-1:0] mask;
        int    first = -1;
        int    cnt   = 0;
        bit    others_ok = 1'b1;
        int    exp_w;
        string req;
        mask  = '0;
        mask[ch] = 1'b1;
        exp_w = (w >= FILT) ? w : 0;
        req   = (w >= FILT) ? "R5" : (base ? "R4" : "R3");
        if (!base) begin
            set_ch(ch, 1'b0);
            wait_neg(FILT + 6);
        end
        ref_o = outs();
        check(ref_o[ch] == base, "R2", "settled base level", int'(ref_o[ch]), int'(base));
        set_ch(ch, ~base);
        for (int i = 0; i < w + FILT + 8; i++) begin
            @(posedge clk);
            @(negedge clk);
            o = outs();
            if (o[ch] != base) begin
                cnt++;
                if (first < 0) first = i;
            end
            if ((o & ~mask) != (ref_o & ~mask)) others_ok = 1'b0;
            if (i + 1 == w) set_ch(ch, base);
        end
        check(cnt == exp_w, req, $sformatf("ch%0d width for input %0d", ch, w), cnt, exp_w);
        if (exp_w > 0)
            check(first == FILT + 1, "R2", $sformatf("ch%0d leading-edge latency", ch), first, FILT + 1);
        check(others_ok, "R1", $sformatf("other channels unchanged, ch%0d active", ch),
              int'(others_ok), 1);
        if (!base) begin
            set_ch(ch, 1'b1);
            wait_neg(FILT + 6);
        end
    endtask

    initial begin : watchdog
        #(20 * 100000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin : main
        // R7: reset state with inputs idle
        wait_neg(3);
        check(outs() == '1, "R7", "outputs during reset", int'(outs()), 63);
        rst = 1'b0;
        wait_neg(1);
        check(outs() == '1, "R7", "outputs just after reset", int'(outs()), 63);
        wait_neg(FILT + 4);

        // table-driven pulses
        for (int v = 0; v < NVEC; v++) begin
            run_pulse(int'(VECS[v][10:8]), VECS[v][11], int'(VECS[v][7:0]));
        end

        // R6: two short dips split by a one-cycle return must be rejected
        begin
            bit stayed = 1'b1;
            set_ch(2, 1'b0);
            for (int i = 0; i < 2 * (FILT - 1) + 1 + FILT + 6; i++) begin
                @(posedge clk);
                @(negedge clk);
                if (hs_out[2] != 1'b1) stayed = 1'b0;
                if (i + 1 == FILT - 1)     set_ch(2, 1'b1);
                if (i + 1 == FILT)         set_ch(2, 1'b0);
                if (i + 1 == 2 * FILT - 1) set_ch(2, 1'b1);
            end
            check(stayed, "R6", "split dips on hs2 rejected", int'(stayed), 1);
        end

        // R1: simultaneous activity, different widths on hs0 and ls2
        begin
            int w_hs0 = 0;
            int w_ls2 = 0;
            hs_in[0] = 1'b0;
            ls_in[2] = 1'b0;
            for (int i = 0; i < 10 + FILT + 8; i++) begin
                @(posedge clk);
                @(negedge clk);
                if (!hs_out[0]) w_hs0++;
                if (!ls_out[2]) w_ls2++;
                if (i + 1 == 5)  ls_in[2] = 1'b1;
                if (i + 1 == 10) hs_in[0] = 1'b1;
            end
            check(w_hs0 == 10, "R1", "hs0 width with ls2 active", w_hs0, 10);
            check(w_ls2 == 0,  "R1", "ls2 short dip with hs0 active", w_ls2, 0);
        end

        // R7: reset while an output is active
        ls_in[1] = 1'b0;
        wait_neg(FILT + 4);
        check(ls_out[1] == 1'b0, "R2", "ls1 low before reset", int'(ls_out[1]), 0);
        rst = 1'b1;
        wait_neg(1);
        check(outs() == '1, "R7", "outputs one edge into reset", int'(outs()), 63);
        ls_in[1] = 1'b1;
        wait_neg(2);
        rst = 1'b0;
        wait_neg(FILT + 4);
        check(outs() == '1, "R7", "outputs idle after reset release", int'(outs()), 63);

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule